// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block puts a small microcontroller into its power-down state and brings it back out. The core sends a one-cycle sleep request. The controller then stops the oscillator enable, freezes the port pad values, and updates two status flags: a time-out flag and a power-down flag. While the device sleeps, a free-running watchdog counter keeps counting. The controller watches three wake sources: the external reset input, the watchdog time-out, and a mismatch between four monitored input pins and a snapshot of those pins.

Execution never resumes from a wake. Every wake event starts a device reset pulse. The status flags keep their values through that pulse, so software can tell afterwards what woke the device. The pin snapshot is taken only when the core strobes a port read. If the pins already differ from the snapshot when sleep is requested, the device wakes at once. The watchdog also resets the running device when it expires. An external reset asserted while awake also resets it.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: A sleep request that the controller accepts in the running state sets `asleep`, clears `osc_en`, sets `to_flag` to 1 and clears `pd_flag` to 0, all visible one cycle after the request. A sleep request has no effect while the reset pulse is active.
- R2: Accepting a sleep request clears the watchdog counter, and the counter keeps counting while asleep. With the watchdog enabled and no other wake source, the device stays asleep for exactly `WDT_LIMIT` cycles.
- R3: `port_out` and `port_oe` keep the values the core drove in the cycle of the sleep request for the whole time `asleep` is 1. After power-up both are 0, and `port_oe` = 0 means high impedance.
- R4: Only three events end sleep: the external reset (`ext_rst_n` low), a watchdog time-out when `wdt_en` = 1, and a pin/snapshot mismatch when `woc_en` = 1. Pin changes with `woc_en` = 0, and a watchdog with `wdt_en` = 0, leave the device asleep.
- R5: Every wake, and power-up, drives `dev_rst` high with `osc_en` high for `RST_CYC` cycles once the external reset is released, after which the running state resumes.
- R6: A watchdog wake clears `to_flag` to 0. A pin-change wake sets `woc_flag` to 1. An external-reset wake leaves `to_flag` = 1, `pd_flag` = 0 and `woc_flag` unchanged.
- R7: `pd_flag` is 1 after power-up reset and is cleared only by an accepted sleep request. No wake or watchdog reset sets it again.
- R8: A port-read strobe in the running state loads the snapshot from the synchronised pins. If the snapshot already differs when sleep is entered and `woc_en` = 1, the device wakes after exactly one sleep cycle. A matching snapshot keeps it asleep.
- R9: A port-read strobe in the running state clears `woc_flag` to 0, visible one cycle later.
- R10: The watchdog is held clear during the reset pulse and is cleared by `wdt_kick`. An expiry while running issues a reset with `to_flag` = 0 after `WDT_LIMIT` running cycles without a kick.
- R11: `ext_rst_n` and `pins_in` pass through a two-stage synchroniser. A held external reset keeps `dev_rst` high for `RST_CYC`+1 cycles after its release is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| sleep_cmd | input | 1 | One-cycle sleep request from the core |
| wdt_kick | input | 1 | Watchdog clear from the core |
| wdt_en | input | 1 | Watchdog enable |
| woc_en | input | 1 | Wake-on-pin-change enable |
| port_rd | input | 1 | Port read strobe, loads the pin snapshot |
| ext_rst_n | input | 1 | External reset input, active low, asynchronous |
| pins_in | input | PIN_W | Monitored input pins, asynchronous |
| core_out | input | PIN_W | Port output values from the core |
| core_oe | input | PIN_W | Port drive enables from the core |
| osc_en | output | 1 | Oscillator enable |
| dev_rst | output | 1 | Device reset pulse |
| asleep | output | 1 | Power-down state indicator |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |
| woc_flag | output | 1 | Wake-on-change status flag |
| port_out | output | PIN_W | Held port output values to the pads |
| port_oe | output | PIN_W | Held port drive enables to the pads |

## Verification
The assertions check on every cycle that the flags and the oscillator enable are right on sleep entry. They also check that pads stay frozen while asleep, that each exit from sleep traces back to an enabled wake cause, and that the reset pulse lasts at least `RST_CYC` cycles. They check as well that `pd_flag` can only fall on sleep entry and that a port read clears `woc_flag`. Some properties are exact counts over a whole scenario: the sleep duration equal to the watchdog limit, the one-cycle wake from a stale snapshot, the stretched reset during a held external reset, and the timing of a kicked watchdog. Only the bench's scenarios and its cycle-by-cycle reference model can show these.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    SWK_RUN   = 2'd0,
    SWK_SLEEP = 2'd1,
    SWK_RESET = 2'd2
  } swk_state_e;
endpackage

// File: rtl/swk_sync.sv
module swk_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= {W{RST_VAL}};
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= {W{RST_VAL}};
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swk_wdt.sv
module swk_wdt #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (expire) cnt <= '0;
    else if (en)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/swk_pinchg.sv
module swk_pinchg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_s,
  input  logic         take,
  input  logic         hit,
  output logic         differ,
  output logic         flag
);
  logic [W-1:0] snap;

  assign differ = (snap != pins_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
      flag <= 1'b0;
    end else begin
      if (take) begin
        snap <= pins_s;
        flag <= 1'b0;
      end else if (hit) begin
        flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swk_pkg::*;
#(
  parameter int PIN_W     = 4,
  parameter int WDT_LIMIT = 256,
  parameter int RST_CYC   = 4,
  parameter int SYNC_N    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_cmd,
  input  logic             wdt_kick,
  input  logic             wdt_en,
  input  logic             woc_en,
  input  logic             port_rd,
  input  logic             ext_rst_n,
  input  logic [PIN_W-1:0] pins_in,
  input  logic [PIN_W-1:0] core_out,
  input  logic [PIN_W-1:0] core_oe,
  output logic             osc_en,
  output logic             dev_rst,
  output logic             asleep,
  output logic             to_flag,
  output logic             pd_flag,
  output logic             woc_flag,
  output logic [PIN_W-1:0] port_out,
  output logic [PIN_W-1:0] port_oe
);
  localparam int RCW = $clog2(RST_CYC + 1);
  localparam logic [RCW-1:0] RC_LAST = RCW'(RST_CYC - 1);

  swk_state_e     state;
  logic [RCW-1:0] rcnt;
  logic [PIN_W-1:0] pins_s;
  logic           ext_n_s;
  logic           ext_act;
  logic           wdt_to;
  logic           pin_mis;

  logic in_run, in_sleep, in_reset;
  logic run_to_rst, sleep_go, kick_go, rd_go;
  logic wake_wdt, wake_pin, wake_any;
  logic wdt_clr;

  swk_sync #(.W(PIN_W), .STAGES(SYNC_N), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .rst(rst), .d(pins_in), .q(pins_s)
  );

  swk_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .rst(rst), .d(ext_rst_n), .q(ext_n_s)
  );

  assign ext_act  = ~ext_n_s;
  assign in_run   = (state == SWK_RUN);
  assign in_sleep = (state == SWK_SLEEP);
  assign in_reset = (state == SWK_RESET);

  assign run_to_rst = in_run && (ext_act || wdt_to);
  assign sleep_go   = in_run && sleep_cmd && !ext_act && !wdt_to;
  assign kick_go    = in_run && wdt_kick;
  assign rd_go      = in_run && port_rd;

  assign wake_wdt = in_sleep && wdt_to;
  assign wake_pin = in_sleep && woc_en && pin_mis;
  assign wake_any = (in_sleep && ext_act) || wake_wdt || wake_pin;

  assign wdt_clr = in_reset || run_to_rst || sleep_go || kick_go || wake_any;

  swk_wdt #(.LIMIT(WDT_LIMIT)) u_wdt (
    .clk(clk), .rst(rst), .en(wdt_en), .clr(wdt_clr), .expire(wdt_to)
  );

  swk_pinchg #(.W(PIN_W)) u_pinchg (
    .clk(clk), .rst(rst), .pins_s(pins_s), .take(rd_go),
    .hit(wake_pin), .differ(pin_mis), .flag(woc_flag)
  );

  // state machine and reset stretch
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SWK_RESET;
      rcnt  <= '0;
    end else begin
      unique case (state)
        SWK_RUN: begin
          if (run_to_rst) begin
            state <= SWK_RESET;
            rcnt  <= '0;
          end else if (sleep_go) begin
            state <= SWK_SLEEP;
          end
        end
        SWK_SLEEP: begin
          if (wake_any) begin
            state <= SWK_RESET;
            rcnt  <= '0;
          end
        end
        SWK_RESET: begin
          if (ext_act)              rcnt <= '0;
          else if (rcnt == RC_LAST) state <= SWK_RUN;
          else                      rcnt <= rcnt + 1'b1;
        end
        default: state <= SWK_RESET;
      endcase
    end
  end

  // status flags
  always_ff @(posedge clk) begin
    if (rst) begin
      to_flag <= 1'b1;
      pd_flag <= 1'b1;
    end else begin
      if (sleep_go) begin
        to_flag <= 1'b1;
        pd_flag <= 1'b0;
      end
      if (wake_wdt || (in_run && wdt_to && !ext_act)) to_flag <= 1'b0;
    end
  end

  // pad hold
  always_ff @(posedge clk) begin
    if (rst) begin
      port_out <= '0;
      port_oe  <= '0;
    end else if (!in_sleep) begin
      port_out <= core_out;
      port_oe  <= core_oe;
    end
  end

  assign osc_en  = !in_sleep;
  assign asleep  = in_sleep;
  assign dev_rst = in_reset;
endmodule

// File: rtl/swk_chk.sv
module swk_chk #(
  parameter int PIN_W   = 4,
  parameter int RST_CYC = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             asleep,
  input logic             osc_en,
  input logic             dev_rst,
  input logic             to_flag,
  input logic             pd_flag,
  input logic             woc_flag,
  input logic             port_rd,
  input logic             wdt_en,
  input logic             woc_en,
  input logic             ext_act,
  input logic             wdt_to,
  input logic             pin_mis,
  input logic [PIN_W-1:0] port_out,
  input logic [PIN_W-1:0] port_oe
);
  int rlen;

  always_ff @(posedge clk) begin
    if (rst)          rlen <= 0;
    else if (dev_rst) rlen <= rlen + 1;
    else              rlen <= 0;
  end

  // R1
  sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> (to_flag && !pd_flag && !osc_en));

  // R3
  pad_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (asleep && $past(asleep)) |-> ($stable(port_out) && $stable(port_oe)));

  // R4
  wake_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep) |-> $past(ext_act || (wdt_en && wdt_to) || (woc_en && pin_mis)));

  // R5
  wake_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep) |-> (dev_rst && osc_en));

  // R5
  rst_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dev_rst) |-> (rlen >= RST_CYC));

  // R7
  pd_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_flag) |-> $rose(asleep));

  // R7
  pd_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(pd_flag));

  // R9
  woc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(port_rd && !asleep && !dev_rst) |-> !woc_flag);
endmodule

bind sleep_wake_ctrl swk_chk #(.PIN_W(PIN_W), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst(rst), .asleep(asleep), .osc_en(osc_en), .dev_rst(dev_rst),
  .to_flag(to_flag), .pd_flag(pd_flag), .woc_flag(woc_flag), .port_rd(port_rd),
  .wdt_en(wdt_en), .woc_en(woc_en), .ext_act(ext_act), .wdt_to(wdt_to),
  .pin_mis(pin_mis), .port_out(port_out), .port_oe(port_oe)
);

// File: tb/sleep_wake_ctrl_bench.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_bench;
  localparam int PW  = 4;
  localparam int WL  = 256;
  localparam int RC  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_cmd = 0, wdt_kick = 0, wdt_en = 0, woc_en = 0, port_rd = 0;
  logic ext_rst_n = 1;
  logic [PW-1:0] pins_in = '0, core_out = '0, core_oe = '0;
  logic osc_en, dev_rst, asleep, to_flag, pd_flag, woc_flag;
  logic [PW-1:0] port_out, port_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl #(.PIN_W(PW), .WDT_LIMIT(WL), .RST_CYC(RC)) u_sleep_wake_ctrl (
    .clk(clk), .rst(rst), .sleep_cmd(sleep_cmd), .wdt_kick(wdt_kick),
    .wdt_en(wdt_en), .woc_en(woc_en), .port_rd(port_rd), .ext_rst_n(ext_rst_n),
    .pins_in(pins_in), .core_out(core_out), .core_oe(core_oe),
    .osc_en(osc_en), .dev_rst(dev_rst), .asleep(asleep), .to_flag(to_flag),
    .pd_flag(pd_flag), .woc_flag(woc_flag), .port_out(port_out), .port_oe(port_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model: 0 run, 1 sleep, 2 reset
  int m_st, m_rc, m_wd, m_to, m_pd, m_woc, m_snap, m_po, m_poe;
  int pq[$];
  int eq[$];
  bit m_valid = 0;

  always @(posedge clk) begin
    int ps, es, tmo, mis, ext, wake;
    if (rst) begin
      m_st = 2; m_rc = 0; m_wd = 0; m_to = 1; m_pd = 1; m_woc = 0;
      m_snap = 0; m_po = 0; m_poe = 0;
      pq = '{0, 0}; eq = '{1, 1};
      m_valid = 1;
    end else begin
      ps = pq[0]; void'(pq.pop_front()); pq.push_back(int'(pins_in));
      es = eq[0]; void'(eq.pop_front()); eq.push_back(int'(ext_rst_n));
      ext = (es == 0);
      tmo = wdt_en && (m_wd == WL - 1);
      mis = (m_snap != ps);
      if (m_st != 1) begin m_po = core_out; m_poe = core_oe; end
      case (m_st)
        0: begin
          if (port_rd) begin m_snap = ps; m_woc = 0; end
          if (ext) begin m_st = 2; m_rc = 0; m_wd = 0; end
          else if (tmo) begin m_st = 2; m_rc = 0; m_wd = 0; m_to = 0; end
          else if (sleep_cmd) begin m_st = 1; m_to = 1; m_pd = 0; m_wd = 0; end
          else if (wdt_kick) m_wd = 0;
          else if (wdt_en) m_wd = m_wd + 1;
        end
        1: begin
          wake = ext || tmo || (woc_en && mis);
          if (wake) begin
            if (tmo) m_to = 0;
            if (woc_en && mis) m_woc = 1;
            m_st = 2; m_rc = 0; m_wd = 0;
          end else if (wdt_en) m_wd = m_wd + 1;
        end
        default: begin
          m_wd = 0;
          if (ext) m_rc = 0;
          else if (m_rc == RC - 1) m_st = 0;
          else m_rc = m_rc + 1;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (m_valid && !rst && !done) begin
      chk("R1 osc_en vs model", int'(osc_en), int'(m_st != 1));
      chk("R1 asleep vs model", int'(asleep), int'(m_st == 1));
      chk("R5 dev_rst vs model", int'(dev_rst), int'(m_st == 2));
      chk("R6 to_flag vs model", int'(to_flag), m_to);
      chk("R7 pd_flag vs model", int'(pd_flag), m_pd);
      chk("R9 woc_flag vs model", int'(woc_flag), m_woc);
      chk("R3 port_out vs model", int'(port_out), m_po);
      chk("R3 port_oe vs model", int'(port_oe), m_poe);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_cmd = 1; tick(1); sleep_cmd = 0;
  endtask

  task automatic pulse_rd();
    port_rd = 1; tick(1); port_rd = 0;
  endtask

  task automatic count_high_rst(output int n);
    n = 0;
    while (dev_rst && n < 1000) begin n++; tick(1); end
  endtask

  task automatic count_asleep(output int n);
    n = 0;
    while (asleep && n < 5000) begin n++; tick(1); end
  endtask

  task automatic ext_wake();
    ext_rst_n = 0; tick(3); ext_rst_n = 1;
    begin int n; tick(1); count_high_rst(n); end
  endtask

  initial begin
    int n;
    tick(3);
    rst = 0;
    tick(1);
    chk("R5 power-up dev_rst", int'(dev_rst), 1);
    chk("R7 power-up pd_flag", int'(pd_flag), 1);
    chk("R6 power-up to_flag", int'(to_flag), 1);
    chk("R3 power-up port_oe", int'(port_oe), 0);
    count_high_rst(n);

    // external wake, sources disabled
    core_out = 4'h5; core_oe = 4'h3;
    pulse_rd();
    pulse_sleep();
    chk("R1 asleep after request", int'(asleep), 1);
    chk("R1 osc_en off", int'(osc_en), 0);
    chk("R1 to_flag set", int'(to_flag), 1);
    chk("R1 pd_flag cleared", int'(pd_flag), 0);
    core_out = 4'hA; core_oe = 4'hF; pins_in = 4'hF;
    tick(40);
    chk("R4 no wake with sources disabled", int'(asleep), 1);
    chk("R3 port_out held", int'(port_out), 5);
    chk("R3 port_oe held", int'(port_oe), 3);
    ext_rst_n = 0; tick(6); ext_rst_n = 1;
    tick(1);
    count_high_rst(n);
    chk("R11 stretched reset length", n, RC + 1);
    chk("R6 ext wake to_flag", int'(to_flag), 1);
    chk("R6 ext wake pd_flag", int'(pd_flag), 0);
    chk("R6 ext wake woc_flag", int'(woc_flag), 0);

    // watchdog wake
    wdt_en = 1;
    wdt_kick = 1; tick(1); wdt_kick = 0;
    pulse_sleep();
    count_asleep(n);
    chk("R2 sleep length equals watchdog limit", n, WL);
    count_high_rst(n);
    wdt_en = 0;
    chk("R5 reset pulse length", n, RC);
    chk("R6 wdt wake clears to_flag", int'(to_flag), 0);
    chk("R7 pd_flag not set by wake", int'(pd_flag), 0);

    // pin-change wake
    woc_en = 1; pins_in = 4'h0;
    tick(3);
    pulse_rd();
    pulse_sleep();
    tick(5);
    chk("R4 matching pins stay asleep", int'(asleep), 1);
    pins_in = 4'h4;
    count_asleep(n);
    chk("R11 pin wake after sync delay", n, 3);
    count_high_rst(n);
    chk("R6 pin wake sets woc_flag", int'(woc_flag), 1);
    chk("R6 pin wake keeps to_flag", int'(to_flag), 1);

    // stale snapshot
    pulse_sleep();
    count_asleep(n);
    chk("R8 stale snapshot wakes at once", n, 1);
    count_high_rst(n);
    pulse_rd();
    chk("R9 port read clears woc_flag", int'(woc_flag), 0);
    pulse_sleep();
    tick(20);
    chk("R8 fresh snapshot keeps sleep", int'(asleep), 1);
    ext_wake();
    chk("R6 ext wake leaves woc_flag", int'(woc_flag), 0);

    // pin change with wake-on-change disabled
    woc_en = 0; pins_in = 4'h8;
    tick(3);
    pulse_sleep();
    tick(20);
    chk("R4 pin change ignored when disabled", int'(asleep), 1);
    ext_wake();

    // running watchdog expiry
    wdt_en = 1;
    n = 0;
    while (!dev_rst && n < 2000) begin n++; tick(1); end
    chk("R10 run expiry after limit", n, WL);
    chk("R10 run expiry clears to_flag", int'(to_flag), 0);
    chk("R10 run expiry keeps pd_flag", int'(pd_flag), 0);
    count_high_rst(n);
    n = 0;
    while (!dev_rst && n < 2000) begin
      wdt_kick = (n == 50);
      n++;
      tick(1);
    end
    wdt_kick = 0;
    chk("R10 kick delays expiry", n, 51 + WL);
    wdt_en = 0;
    count_high_rst(n);

    // sleep request during reset pulse ignored
    ext_rst_n = 0; tick(4); ext_rst_n = 1;
    pulse_sleep();
    chk("R1 request ignored in reset", int'(asleep), 0);
    count_high_rst(n);

    // power-up again
    rst = 1; tick(2); rst = 0; tick(1);
    chk("R7 pd_flag set by power-up", int'(pd_flag), 1);
    chk("R6 to_flag set by power-up", int'(to_flag), 1);
    count_high_rst(n);
    tick(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule